// File: doc/BRIEF.md
# Serial NOR Flash Program/Erase Sequencer

This block turns a single program or erase request into the full sequence of serial flash transactions that the request needs. The requester gives an operation kind, a 24-bit start address and a byte length. For a program request it also supplies data bytes on demand through an offset/byte pair. The block breaks the request into units of work. A program unit is the part of the data that fits before the next page boundary; an erase unit is one sector. For every unit it sends a write-enable frame, then a command frame with the address, then status-read frames until the device reports ready.

Each byte on the serial bus goes through a byte-level handshake with an external shift engine. The block presents a byte and holds it until the engine acknowledges the byte with a one-cycle done pulse and the byte it received. The block drives chip select itself, so it decides where each frame starts and ends. Readiness always needs the write-in-progress bit to be clear. When the request selects flag polling, a second register must also report its controller-ready bit. A cycle-count timeout bounds polling, with a separate limit for program and for erase. A misaligned erase is refused before any bus traffic.

Top module: `flash_seq`

## Requirements
- R1: Every command frame (opcode 0x02 for program, 0xD8 for erase) comes directly after a one-byte write-enable frame (opcode 0x06). No other frame lies between them.
- R2: A command frame is the opcode followed by address bits 23:16, 15:8 and 7:0 in that order. In a program frame the data bytes follow, and the byte at stream offset k is the `prog_byte` value returned while `prog_off` equals k. An erase frame has exactly four bytes.
- R3: A program request is split at page boundaries. Each unit is min(remaining, PAGE_BYTES - (address mod PAGE_BYTES)) bytes, and the next unit starts where the previous one ended.
- R4: After each command the block sends status-read frames (0x05 followed by one filler byte; the second received byte is the status). It keeps polling while status bit 0 is 1.
- R5: With `flag_poll_en` set at request time, a status byte with bit 0 clear is followed by a flag-read frame (0x70 followed by one filler byte). The unit is ready only if bit 7 of that byte is 1; otherwise polling goes back to status reads.
- R6: Polling for one unit may run for at most PROG_TO cycles on a program and at most ERASE_TO cycles on an erase. If a poll returns not-ready once the limit has been reached, the request ends with `done` and `err`, `err_code` = 2, and no further frame is started.
- R7: An erase whose address or length is not a multiple of ERASE_BYTES ends with `done`, `err` and `err_code` = 1, and chip select is never asserted.
- R8: An erase of n sectors sends n erase commands at start, start+ERASE_BYTES, and so on. If one unit fails, no further sector is started.
- R9: `eng_valid` is high only while `spi_cs_n` is low. `eng_tx` stays constant until `eng_done`. Chip select goes high for at least one cycle between frames.
- R10: A request of length zero (and not rejected under R7) ends with `done` and no error, and chip select is never asserted.
- R11: After reset and after every `done`, the block is idle: `busy` = 0, `spi_cs_n` = 1, `eng_valid` = 0. On success `done` pulses for one cycle with `err` = 0 and `err_code` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while busy is low |
| req_erase | input | 1 | 1 = erase, 0 = program |
| req_addr | input | 24 | Start address |
| req_len | input | LEN_W | Length in bytes |
| flag_poll_en | input | 1 | Also require the flag register's ready bit |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse at the end of a request |
| err | output | 1 | High with done when the request failed |
| err_code | output | 2 | 0 none, 1 misaligned erase, 2 timeout; held until the next request |
| prog_off | output | LEN_W | Stream offset of the program byte wanted now |
| prog_byte | input | 8 | Program data for offset prog_off |
| spi_cs_n | output | 1 | Flash chip select, active low |
| eng_valid | output | 1 | Byte offered to the shift engine |
| eng_tx | output | 8 | Byte to shift out |
| eng_done | input | 1 | Engine finished the current byte |
| eng_rx | input | 8 | Byte shifted in, valid with eng_done |

## Verification
The assertions take for granted that the engine pulses `eng_done` only while `eng_valid` is high and at most once per byte. They also assume `req_valid` arrives only while `busy` is low. The bench's engine model replies two cycles after a byte is offered and drops `eng_done` after one cycle. It acts as the flash, holding the write-in-progress and flag bits for a chosen number of reads after each command. The bench issues each request only after the previous one has completed. Erase and page sizes are powers of two, so alignment reduces to the low address bits.

// File: rtl/flash_seq_pkg.sv
// Shared opcodes, status masks, error codes and state types of the flash sequencer.
package flash_seq_pkg;
    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_PROG  = 8'h02;
    localparam logic [7:0] OPC_ERASE = 8'hD8;
    localparam logic [7:0] OPC_RSR   = 8'h05;
    localparam logic [7:0] OPC_RFSR  = 8'h70;

    localparam logic [7:0] WIP_MASK = 8'h01;   // status bit 0: busy
    localparam logic [7:0] PEC_MASK = 8'h80;   // flag bit 7: controller ready

    localparam logic [1:0] ERR_NONE    = 2'd0;
    localparam logic [1:0] ERR_ALIGN   = 2'd1;
    localparam logic [1:0] ERR_TIMEOUT = 2'd2;

    typedef enum logic [1:0] {FR_WREN, FR_CMD, FR_RSR, FR_RFSR} frame_e;
    typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_GAP, ST_END} state_e;
endpackage

// File: rtl/flash_seq_chunk.sv
// Unit sizing: length of the current program chunk (bounded by the page end)
// or the erase sector, plus erase alignment of a new request.
// Assumes PAGE_BYTES and ERASE_BYTES are powers of two below 2**LEN_W.
module flash_seq_chunk #(
    parameter int LEN_W       = 16,
    parameter int PAGE_BYTES  = 256,
    parameter int ERASE_BYTES = 4096,
    localparam int PG_W = $clog2(PAGE_BYTES),
    localparam int ER_W = $clog2(ERASE_BYTES)
) (
    input  logic             is_erase,
    input  logic [PG_W-1:0]  page_off,
    input  logic [LEN_W-1:0] remain,
    input  logic [ER_W-1:0]  req_addr_lo,
    input  logic [ER_W-1:0]  req_len_lo,
    output logic [LEN_W-1:0] unit_len,
    output logic             misaligned
);
    localparam logic [LEN_W-1:0] PAGE_L  = LEN_W'(PAGE_BYTES);
    localparam logic [LEN_W-1:0] ERASE_L = LEN_W'(ERASE_BYTES);

    logic [LEN_W-1:0] room;

    // Bytes left before the page boundary, and the unit chosen from it.
    always_comb begin
        room = PAGE_L - {{(LEN_W-PG_W){1'b0}}, page_off};
        if (is_erase)
            unit_len = ERASE_L;
        else if (remain < room)
            unit_len = remain;
        else
            unit_len = room;
    end

    // Erase start or length off the sector grid.
    assign misaligned = (|req_addr_lo) | (|req_len_lo);
endmodule

// File: rtl/flash_seq_timer.sv
// Poll timeout counter: cleared when polling for a unit begins, counts while
// polling, saturates at the limit chosen by the operation kind.
module flash_seq_timer #(
    parameter int PROG_TO  = 500000,
    parameter int ERASE_TO = 50000000,
    localparam int MAX_TO = (PROG_TO > ERASE_TO) ? PROG_TO : ERASE_TO,
    localparam int CNT_W  = $clog2(MAX_TO + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic is_erase,
    output logic expired
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Limit for the running operation.
    assign limit   = is_erase ? CNT_W'(ERASE_TO) : CNT_W'(PROG_TO);
    assign expired = cnt >= limit;

    // Cycle counter for the current poll window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (run && !expired)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/flash_seq_ctrl.sv
// Frame sequencer: walks write-enable, command(+data) and poll frames for each
// unit, drives chip select and the byte handshake, and ends the request.
// Assumes eng_done pulses once per offered byte and requests arrive when idle.
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_erase,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_flag,
    input  logic             misaligned,
    input  logic [LEN_W-1:0] unit_len,
    input  logic             expired,
    input  logic [7:0]       prog_byte,
    input  logic             eng_done,
    input  logic [7:0]       eng_rx,
    output logic             timer_clr,
    output logic             timer_run,
    output logic             op_erase,
    output logic [23:0]      cur_addr,
    output logic [LEN_W-1:0] cur_remain,
    output logic [LEN_W-1:0] prog_off,
    output logic             eng_valid,
    output logic [7:0]       eng_tx,
    output logic             spi_cs_n,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [1:0]       err_code
);
    localparam int IDX_W = LEN_W + 1;

    state_e           st;
    frame_e           fr;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] frame_len;
    logic [23:0]      addr_q;
    logic [LEN_W-1:0] remain_q;
    logic [LEN_W-1:0] base_q;
    logic             erase_q;
    logic             flag_q;
    logic [7:0]       rx_q;
    logic [1:0]       err_q;
    logic             wip;
    logic             pec;
    logic             unit_ok;
    logic             to_hit;

    // Frame length in bytes for the frame in flight.
    always_comb begin
        case (fr)
            FR_WREN: frame_len = IDX_W'(1);
            FR_CMD:  frame_len = erase_q ? IDX_W'(4) : IDX_W'(4) + {1'b0, unit_len};
            default: frame_len = IDX_W'(2);
        endcase
    end

    // Byte to send at the current position of the frame.
    always_comb begin
        case (fr)
            FR_WREN: eng_tx = OPC_WREN;
            FR_RSR:  eng_tx = (idx == '0) ? OPC_RSR : 8'h00;
            FR_RFSR: eng_tx = (idx == '0) ? OPC_RFSR : 8'h00;
            default: begin
                case (idx)
                    IDX_W'(0): eng_tx = erase_q ? OPC_ERASE : OPC_PROG;
                    IDX_W'(1): eng_tx = addr_q[23:16];
                    IDX_W'(2): eng_tx = addr_q[15:8];
                    IDX_W'(3): eng_tx = addr_q[7:0];
                    default:   eng_tx = prog_byte;
                endcase
            end
        endcase
    end

    // Readiness decode of the last polled byte and end-of-poll decisions.
    always_comb begin
        wip     = |(rx_q & WIP_MASK);
        pec     = |(rx_q & PEC_MASK);
        unit_ok = (st == ST_GAP) &&
                  (((fr == FR_RSR) && !wip && !flag_q) || ((fr == FR_RFSR) && pec));
        to_hit  = (st == ST_GAP) && expired &&
                  (((fr == FR_RSR) && wip) || ((fr == FR_RFSR) && !pec));
    end

    // Request, unit and frame sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            fr       <= FR_WREN;
            idx      <= '0;
            addr_q   <= '0;
            remain_q <= '0;
            base_q   <= '0;
            erase_q  <= 1'b0;
            flag_q   <= 1'b0;
            rx_q     <= '0;
            err_q    <= ERR_NONE;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        erase_q  <= req_erase;
                        flag_q   <= req_flag;
                        addr_q   <= req_addr;
                        remain_q <= req_len;
                        base_q   <= '0;
                        fr       <= FR_WREN;
                        idx      <= '0;
                        err_q    <= ERR_NONE;
                        if (req_erase && misaligned) begin
                            err_q <= ERR_ALIGN;
                            st    <= ST_END;
                        end else if (req_len == '0) begin
                            st <= ST_END;
                        end else begin
                            st <= ST_FRAME;
                        end
                    end
                end
                ST_FRAME: begin
                    if (eng_done) begin
                        rx_q <= eng_rx;
                        if (idx == frame_len - IDX_W'(1)) begin
                            idx <= '0;
                            st  <= ST_GAP;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    st <= ST_FRAME;
                    if (to_hit) begin
                        err_q <= ERR_TIMEOUT;
                        st    <= ST_END;
                    end else if (unit_ok) begin
                        addr_q   <= addr_q + 24'(unit_len);
                        remain_q <= remain_q - unit_len;
                        base_q   <= base_q + unit_len;
                        fr       <= FR_WREN;
                        if (remain_q == unit_len)
                            st <= ST_END;
                    end else begin
                        case (fr)
                            FR_WREN: fr <= FR_CMD;
                            FR_CMD:  fr <= FR_RSR;
                            FR_RSR:  fr <= wip ? FR_RSR : FR_RFSR;
                            default: fr <= FR_RSR;
                        endcase
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Bus, timer and completion outputs.
    assign eng_valid  = (st == ST_FRAME);
    assign spi_cs_n   = (st != ST_FRAME);
    assign busy       = (st != ST_IDLE);
    assign done       = (st == ST_END);
    assign err        = done && (err_q != ERR_NONE);
    assign err_code   = err_q;
    assign timer_clr  = (st == ST_GAP) && (fr == FR_CMD);
    assign timer_run  = busy && ((fr == FR_RSR) || (fr == FR_RFSR));
    assign op_erase   = erase_q;
    assign cur_addr   = addr_q;
    assign cur_remain = remain_q;
    assign prog_off   = base_q + LEN_W'(idx - IDX_W'(4));
endmodule

// File: rtl/flash_seq.sv
// Top of the serial flash program/erase sequencer: joins unit sizing, the
// poll timeout and the frame sequencer. Page and sector sizes are powers of two.
module flash_seq #(
    parameter int LEN_W       = 16,
    parameter int PAGE_BYTES  = 256,
    parameter int ERASE_BYTES = 4096,
    parameter int PROG_TO     = 500000,
    parameter int ERASE_TO    = 50000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_erase,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             flag_poll_en,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [1:0]       err_code,
    output logic [LEN_W-1:0] prog_off,
    input  logic [7:0]       prog_byte,
    output logic             spi_cs_n,
    output logic             eng_valid,
    output logic [7:0]       eng_tx,
    input  logic             eng_done,
    input  logic [7:0]       eng_rx
);
    localparam int PG_W = $clog2(PAGE_BYTES);
    localparam int ER_W = $clog2(ERASE_BYTES);

    logic [LEN_W-1:0] unit_len;
    logic [LEN_W-1:0] cur_remain;
    logic [23:0]      cur_addr;
    logic             misaligned;
    logic             expired;
    logic             timer_clr;
    logic             timer_run;
    logic             op_erase;

    flash_seq_chunk #(
        .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .ERASE_BYTES(ERASE_BYTES)
    ) u_chunk (
        .is_erase    (op_erase),
        .page_off    (cur_addr[PG_W-1:0]),
        .remain      (cur_remain),
        .req_addr_lo (req_addr[ER_W-1:0]),
        .req_len_lo  (req_len[ER_W-1:0]),
        .unit_len    (unit_len),
        .misaligned  (misaligned)
    );

    flash_seq_timer #(
        .PROG_TO(PROG_TO), .ERASE_TO(ERASE_TO)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (timer_clr),
        .run      (timer_run),
        .is_erase (op_erase),
        .expired  (expired)
    );

    flash_seq_ctrl #(
        .LEN_W(LEN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_erase  (req_erase),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .req_flag   (flag_poll_en),
        .misaligned (misaligned),
        .unit_len   (unit_len),
        .expired    (expired),
        .prog_byte  (prog_byte),
        .eng_done   (eng_done),
        .eng_rx     (eng_rx),
        .timer_clr  (timer_clr),
        .timer_run  (timer_run),
        .op_erase   (op_erase),
        .cur_addr   (cur_addr),
        .cur_remain (cur_remain),
        .prog_off   (prog_off),
        .eng_valid  (eng_valid),
        .eng_tx     (eng_tx),
        .spi_cs_n   (spi_cs_n),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .err_code   (err_code)
    );
endmodule

// File: rtl/flash_seq_chk.sv
// Protocol checker for flash_seq, attached by bind. Tracks the opcode of each
// frame to check write-enable ordering; assumes a well-behaved byte engine.
module flash_seq_chk
    import flash_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [1:0] err_code,
    input logic       spi_cs_n,
    input logic       eng_valid,
    input logic [7:0] eng_tx,
    input logic       eng_done
);
    logic       first_pend;
    logic [7:0] prev_op;

    // Remember the opcode of the previous frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_pend <= 1'b1;
            prev_op    <= 8'h00;
        end else if (spi_cs_n) begin
            first_pend <= 1'b1;
        end else if (eng_valid && eng_done && first_pend) begin
            first_pend <= 1'b0;
            prev_op    <= eng_tx;
        end
    end

    // R1: a command opcode only right after a write-enable frame
    p_wren_before_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && first_pend && ((eng_tx == OPC_PROG) || (eng_tx == OPC_ERASE)))
        |-> (prev_op == OPC_WREN));

    // R9: bytes only inside a frame
    p_byte_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid |-> !spi_cs_n);

    // R9: offered byte held until acknowledged
    p_tx_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_done) |=> (eng_valid && $stable(eng_tx)));

    // R11: idle leaves the bus quiet
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n && !eng_valid));

    // R11: back to idle after done
    p_done_to_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R6: error only with done and a nonzero code
    p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && (err_code != 2'd0)));

    // R6: nothing started after a timeout
    p_quiet_after_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err && (err_code == 2'd2)) |=> (spi_cs_n && !eng_valid));

    // R7: rejected erase never touched the bus
    p_align_no_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (err_code == 2'd1)) |-> (spi_cs_n && $past(spi_cs_n)));
endmodule

bind flash_seq flash_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .err_code  (err_code),
    .spi_cs_n  (spi_cs_n),
    .eng_valid (eng_valid),
    .eng_tx    (eng_tx),
    .eng_done  (eng_done)
);

// File: tb/flash_seq_tb_top.sv
// Bench: a byte-engine/flash model plus sweeps of program and erase requests.
module flash_seq_tb_top;
    localparam int LEN_W = 12;
    localparam int PAGE  = 8;
    localparam int SECT  = 16;
    localparam int PTO   = 200;
    localparam int ETO   = 400;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_erase = 1'b0;
    logic [23:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             flag_poll_en = 1'b0;
    logic             busy, done, err;
    logic [1:0]       err_code;
    logic [LEN_W-1:0] prog_off;
    logic [7:0]       prog_byte;
    logic             spi_cs_n, eng_valid;
    logic [7:0]       eng_tx;
    logic             eng_done;
    logic [7:0]       eng_rx;

    always #5 clk = ~clk;

    flash_seq #(
        .LEN_W(LEN_W), .PAGE_BYTES(PAGE), .ERASE_BYTES(SECT),
        .PROG_TO(PTO), .ERASE_TO(ETO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
        .req_addr(req_addr), .req_len(req_len), .flag_poll_en(flag_poll_en),
        .busy(busy), .done(done), .err(err), .err_code(err_code),
        .prog_off(prog_off), .prog_byte(prog_byte), .spi_cs_n(spi_cs_n),
        .eng_valid(eng_valid), .eng_tx(eng_tx), .eng_done(eng_done), .eng_rx(eng_rx)
    );

    function automatic logic [7:0] pat(input int off);
        int v;
        v = off * 13 + 90;
        return v[7:0];
    endfunction

    always_comb prog_byte = pat(int'(prog_off));

    // ---------------- flash / engine model ----------------
    int bidx, fdlen, busy_left, pec_left, cfg_busy, cfg_pec;
    int n_cmd, n_rsr, n_rfsr, n_frames, wel_viol, data_bad, out_viol;
    int base_addr;
    logic [7:0]  fop;
    logic [23:0] faddr;
    logic        wel;
    logic [7:0]  cmd_op [0:63];
    int          cmd_addr [0:63];
    int          cmd_dlen [0:63];

    always @(posedge clk) begin
        logic [7:0] rx;
        if (!rst_n) begin
            eng_done <= 1'b0;
            eng_rx   <= 8'h00;
            bidx = 0;
            wel = 1'b0;
        end else begin
            eng_done <= 1'b0;
            if (eng_valid && spi_cs_n) out_viol++;
            if (spi_cs_n) begin
                if (bidx > 0) begin
                    n_frames++;
                    if (fop == 8'h06) wel = 1'b1;
                    else if (fop == 8'h02 || fop == 8'hD8) begin
                        if (!wel || bidx < 4) wel_viol++;
                        wel = 1'b0;
                        if (n_cmd < 64) begin
                            cmd_op[n_cmd]   = fop;
                            cmd_addr[n_cmd] = int'(faddr);
                            cmd_dlen[n_cmd] = fdlen;
                        end
                        n_cmd++;
                        busy_left = cfg_busy;
                        pec_left  = cfg_pec;
                    end else if (fop == 8'h05) n_rsr++;
                    else if (fop == 8'h70) n_rfsr++;
                    else wel_viol++;
                end
                bidx = 0;
            end else if (eng_valid && !eng_done) begin
                rx = 8'h00;
                if (bidx == 0) begin
                    fop = eng_tx; faddr = '0; fdlen = 0;
                end else if (bidx <= 3) begin
                    faddr = {faddr[15:0], eng_tx};
                end else begin
                    if (eng_tx !== pat(int'(faddr) - base_addr + bidx - 4)) data_bad++;
                    fdlen++;
                end
                if (bidx == 1 && fop == 8'h05) begin
                    rx = (busy_left > 0) ? 8'h01 : 8'h00;
                    if (busy_left > 0) busy_left--;
                end
                if (bidx == 1 && fop == 8'h70) begin
                    rx = (pec_left == 0) ? 8'h80 : 8'h00;
                    if (pec_left > 0) pec_left--;
                end
                eng_rx   <= rx;
                eng_done <= 1'b1;
                bidx++;
            end
        end
    end

    // ---------------- checking ----------------
    int n_checks = 0, n_fail = 0;
    bit r_err;
    int r_code;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
            finish_run();
        end
    end

    task automatic run(input bit er, input int addr, input int len, input bit fl,
                       input int bz, input int pc);
        int w;
        cfg_busy = bz; cfg_pec = pc; base_addr = addr;
        n_cmd = 0; n_rsr = 0; n_rfsr = 0; n_frames = 0;
        wel_viol = 0; data_bad = 0; out_viol = 0;
        @(negedge clk);
        req_valid = 1'b1; req_erase = er; req_addr = addr[23:0];
        req_len = len[LEN_W-1:0]; flag_poll_en = fl;
        @(negedge clk);
        req_valid = 1'b0;
        w = 0;
        while (!done && w < 20000) begin
            @(negedge clk);
            w++;
        end
        chk(done, "R11 done seen", done, 1);
        r_err = err; r_code = int'(err_code);
        @(negedge clk);
        chk(!busy && spi_cs_n && !eng_valid, "R11 idle after done", busy, 0);
    endtask

    task automatic check_program(input int addr, input int len, input int bz);
        int a, rem, c, i, bad;
        a = addr; rem = len; i = 0; bad = 0;
        while (rem > 0) begin
            c = PAGE - (a % PAGE);
            if (rem < c) c = rem;
            if (i >= n_cmd || cmd_op[i] != 8'h02 || cmd_addr[i] != a || cmd_dlen[i] != c) bad++;
            a += c; rem -= c; i++;
        end
        chk(!r_err && r_code == 0, "R11 program no error", r_code, 0);
        chk(n_cmd == i, "R3 unit count", n_cmd, i);
        chk(bad == 0, "R3 unit addresses and lengths", bad, 0);
        chk(data_bad == 0, "R2 data stream", data_bad, 0);
        chk(wel_viol == 0, "R1 write enable ahead", wel_viol, 0);
        chk(n_rsr == n_cmd * (bz + 1), "R4 status polls", n_rsr, n_cmd * (bz + 1));
        chk(out_viol == 0, "R9 byte inside frame", out_viol, 0);
        if (len == 0) chk(n_frames == 0, "R10 zero length quiet", n_frames, 0);
    endtask

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        chk(!busy && spi_cs_n && !eng_valid && !done, "R11 reset state", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && spi_cs_n && !done && !err, "R11 idle after reset", busy, 0);

        // Program sweep over start offset and length (R2, R3, R4, R10)
        for (int a = 0; a < 16; a++) begin
            for (int l = 0; l < 18; l++) begin
                run(1'b0, 24'h3C7FF0 + a, l, 1'b0, a % 3, 0);
                check_program(24'h3C7FF0 + a, l, a % 3);
            end
        end

        // Multi-sector erase sweep (R8, R2, R10)
        for (int k = 0; k < 4; k++) begin
            for (int n = 0; n < 5; n++) begin
                int bad;
                run(1'b1, 24'h12FFC0 + k * SECT, n * SECT, 1'b0, 1, 0);
                bad = 0;
                for (int i = 0; i < n; i++)
                    if (i >= n_cmd || cmd_op[i] != 8'hD8 || cmd_dlen[i] != 0 ||
                        cmd_addr[i] != 24'h12FFC0 + (k + i) * SECT) bad++;
                chk(!r_err && n_cmd == n, "R8 sector count", n_cmd, n);
                chk(bad == 0, "R8 sector addresses", bad, 0);
                chk(wel_viol == 0, "R1 erase write enable", wel_viol, 0);
                if (n == 0) chk(n_frames == 0, "R10 empty erase quiet", n_frames, 0);
            end
        end

        // Misaligned erase rejected (R7)
        for (int o = 1; o < SECT; o++) begin
            run(1'b1, 24'h004000 + o, SECT, 1'b0, 0, 0);
            chk(r_err && r_code == 1 && n_frames == 0, "R7 misaligned start", r_code, 1);
            run(1'b1, 24'h004000, SECT + o, 1'b0, 0, 0);
            chk(r_err && r_code == 1 && n_frames == 0, "R7 misaligned length", r_code, 1);
        end

        // Flag polling (R5)
        for (int b = 0; b < 3; b++) begin
            for (int p = 0; p < 3; p++) begin
                run(1'b0, 24'h000100, 4, 1'b1, b, p);
                chk(!r_err && n_cmd == 1, "R5 flag mode completes", n_cmd, 1);
                chk(n_rfsr == p + 1, "R5 flag reads", n_rfsr, p + 1);
                chk(n_rsr == b + 1 + p, "R5 status reads", n_rsr, b + 1 + p);
                run(1'b1, 24'h000200, SECT, 1'b1, b, p);
                chk(!r_err && n_rfsr == p + 1, "R5 erase flag reads", n_rfsr, p + 1);
            end
        end

        // Timeouts (R6) and stop on failure (R8)
        run(1'b0, 24'h000300, 4, 1'b0, 50, 0);
        chk(r_err && r_code == 2, "R6 program timeout", r_code, 2);
        chk(n_cmd == 1, "R6 one command before timeout", n_cmd, 1);
        begin
            int f0;
            f0 = n_frames;
            repeat (40) @(negedge clk);
            chk(n_frames == f0 && spi_cs_n, "R6 no frame after timeout", n_frames, f0);
        end
        run(1'b1, 24'h000400, SECT, 1'b0, 50, 0);
        chk(!r_err && r_code == 0, "R6 longer erase limit", r_code, 0);
        run(1'b1, 24'h000400, 3 * SECT, 1'b0, 200, 0);
        chk(r_err && r_code == 2, "R6 erase timeout", r_code, 2);
        chk(n_cmd == 1, "R8 stop at first failure", n_cmd, 1);
        run(1'b0, 24'h000500, 8, 1'b1, 5, 50);
        chk(r_err && r_code == 2, "R6 flag timeout", r_code, 2);

        // Recovery after an error (R11)
        run(1'b0, 24'h000606, 5, 1'b0, 0, 0);
        check_program(24'h000606, 5, 0);

        finish_run();
    end
endmodule